// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a memory-mapped timer that produces a steady stream of period events from the core clock. A fixed divide-by-sixteen stage feeds a period counter. The period counter climbs from zero to a programmed limit and then returns to zero. Each return, called a wrap, sets a sticky event flag and adds one to a 12-bit tally of elapsed periods. The tally lets software that answers late see how many periods it missed. A level interrupt follows the event flag when interrupts are unmasked.

Software sees two read views with the same layout: the elapsed-period tally and the live count. One view acknowledges: reading it clears the flag and the tally. The other view only observes. A small run sequencer has three states. In `ST_IDLE` the counter and divider are held at zero. In `ST_RUN` the timer counts freely. In `ST_DRAIN` the run enable has been withdrawn, but the current period still completes.

The sequencer has five transitions:
- `ST_IDLE` → `ST_RUN` when the enable is set.
- `ST_RUN` → `ST_DRAIN` when the enable is cleared.
- `ST_DRAIN` → `ST_RUN` when the enable is set again.
- `ST_DRAIN` → `ST_IDLE` at the wrap that ends the period.
- `ST_DRAIN` → `ST_RUN` at that same wrap if the enable has already returned.

Reads are combinational within the cycle in which `bus_rd` is high. Writes and read side effects take effect at the following clock edge.

Top module: `tick_timer`

## Requirements
- R1: While running, the period counter advances once every 16 clock cycles. Consecutive wraps are exactly 16 × (limit + 1) clock cycles apart.
- R2: The control word sits at byte offset 0x0. Bits [19:0] hold the period limit, bit 24 is the run enable and bit 25 is the interrupt unmask. Reading it back returns those fields, and every other bit reads as zero whatever was written.
- R3: A wrap occurs when the count, which is at or above the limit, returns to zero. A wrap sets the event flag, which reads as bit 0 at offset 0x4; all other bits at that offset read as zero.
- R4: A read at offset 0x8 returns the tally in bits [31:20] and the live count in bits [19:0], using the values from before the read. It then clears both the event flag and the tally.
- R5: A read at offset 0xC returns the same layout as offset 0x8 and changes neither the flag nor the tally.
- R6: Each wrap adds one to the tally. Once the tally reaches 4095 it stays there until an acknowledging read.
- R7: If a wrap coincides with an acknowledging read, the event flag stays set and the tally becomes exactly 1.
- R8: `irq` is high exactly when the event flag is set and the interrupt unmask is set. With the unmask clear, the flag and the tally still update.
- R9: After the run enable is cleared, counting continues to the end of the current period, and that final wrap is recorded. The counter then holds at zero with the divider stopped.
- R10: Reset clears every register and counter. A read of any offset other than 0x0, 0x4, 0x8 and 0xC returns zero, and `bus_rdata` is zero whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; the acknowledging side effect acts at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Level interrupt request |

## Verification
The checker assumes that `bus_rd` and `bus_wr` are never high together, because the two strobes share one address. The stimulus issues one access at a time, changes inputs one time unit after a rising edge and returns the strobes low after one cycle. The saturation and coincidence properties also assume that the limit is not reprogrammed between a wrap and its acknowledgement. The bench only rewrites the control word after clearing the event with an acknowledging read, and it places the coincident read by counting cycles from an observed interrupt rise.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } run_state_t;

    localparam int OFF_CTRL = 0;
    localparam int OFF_FLAG = 4;
    localparam int OFF_ACK  = 8;
    localparam int OFF_PEEK = 12;

    localparam int EN_BIT = 24;
    localparam int IE_BIT = 25;

endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_bypass
            assign tick = active;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] pre_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)              pre_q <= '0;
                else if (!active)        pre_q <= '0;
                else if (pre_q == LAST)  pre_q <= '0;
                else                     pre_q <= pre_q + 1'b1;
            end

            assign tick = active && (pre_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/tick_sequencer.sv
module tick_sequencer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             active,
    output logic             wrap,
    output logic [CNT_W-1:0] count
);
    run_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    assign wrap   = tick && (cnt_q >= limit);
    assign active = (state_q != ST_IDLE);
    assign count  = cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_en) state_d = ST_RUN;
            ST_RUN:   if (!run_en) state_d = ST_DRAIN;
            ST_DRAIN: begin
                if (run_en)     state_d = ST_RUN;
                else if (wrap)  state_d = ST_IDLE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (wrap)              cnt_q <= '0;
        else if (tick)              cnt_q <= cnt_q + 1'b1;
        else if (state_q == ST_IDLE) cnt_q <= '0;
    end
endmodule

// File: rtl/tick_event_log.sv
module tick_event_log #(
    parameter int OVF_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             ack,
    output logic             flag,
    output logic [OVF_W-1:0] tally
);
    localparam logic [OVF_W-1:0] TOP = {OVF_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            tally <= '0;
        end else if (ack) begin
            flag  <= wrap;
            tally <= wrap ? OVF_W'(1) : '0;
        end else if (wrap) begin
            flag  <= 1'b1;
            tally <= (tally == TOP) ? tally : tally + 1'b1;
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int CNT_W    = 20,
    parameter int OVF_W    = 12,
    parameter int PRESCALE = 16,
    parameter int AW       = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [31:0]   bus_wdata,
    input  logic          bus_rd,
    output logic [31:0]   bus_rdata,
    output logic          irq
);
    localparam int DW = 32;

    logic [CNT_W-1:0] limit_q;
    logic             run_en_q;
    logic             irq_en_q;
    logic             tick, wrap, active, ack, evt_flag;
    logic [CNT_W-1:0] seq_cnt;
    logic [OVF_W-1:0] evt_tally;
    logic [DW-1:0]    view, ctrl_word;

    wire unused_wbits = ^{bus_wdata[DW-1:IE_BIT+1], bus_wdata[EN_BIT-1:CNT_W]};

    assign ack = bus_rd && (int'(bus_addr) == OFF_ACK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q  <= '0;
            run_en_q <= 1'b0;
            irq_en_q <= 1'b0;
        end else if (bus_wr && (int'(bus_addr) == OFF_CTRL)) begin
            limit_q  <= bus_wdata[CNT_W-1:0];
            run_en_q <= bus_wdata[EN_BIT];
            irq_en_q <= bus_wdata[IE_BIT];
        end
    end

    tick_prescale #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .active(active), .tick(tick)
    );

    tick_sequencer #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run_en(run_en_q), .tick(tick),
        .limit(limit_q), .active(active), .wrap(wrap), .count(seq_cnt)
    );

    tick_event_log #(.OVF_W(OVF_W)) u_log (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack),
        .flag(evt_flag), .tally(evt_tally)
    );

    always_comb begin
        view = '0;
        view[CNT_W-1:0]     = seq_cnt;
        view[CNT_W +: OVF_W] = evt_tally;
        ctrl_word = '0;
        ctrl_word[CNT_W-1:0] = limit_q;
        ctrl_word[EN_BIT]    = run_en_q;
        ctrl_word[IE_BIT]    = irq_en_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (int'(bus_addr))
                OFF_CTRL: bus_rdata = ctrl_word;
                OFF_FLAG: bus_rdata = {{(DW-1){1'b0}}, evt_flag};
                OFF_ACK:  bus_rdata = view;
                OFF_PEEK: bus_rdata = view;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq = evt_flag && irq_en_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W = 20,
    parameter int OVF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ack,
    input logic             wrap,
    input logic             active,
    input logic             evt_flag,
    input logic [OVF_W-1:0] evt_tally,
    input logic [CNT_W-1:0] seq_cnt,
    input logic             irq_en_q,
    input logic             irq
);
    localparam logic [OVF_W-1:0] TOP = {OVF_W{1'b1}};

    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !ack) |=> evt_flag);

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !wrap) |=> (!evt_flag && evt_tally == '0));

    a_r7_coincident: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && wrap) |=> (evt_flag && evt_tally == OVF_W'(1)));

    a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tally == TOP && !ack) |=> evt_tally == TOP);

    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !wrap) |=> $stable(evt_tally));

    a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en_q |-> !irq);

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (seq_cnt == '0));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .wrap(wrap), .active(active),
    .evt_flag(evt_flag), .evt_tally(evt_tally), .seq_cnt(seq_cnt),
    .irq_en_q(irq_en_q), .irq(irq)
);

// File: tb/tick_timer_bench.sv
`timescale 1ns/1ps
module tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    tick_timer u_tick_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: pops one expectation per read cycle
    always @(negedge clk) begin
        if (bus_rd && sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            if (it.mask != 0) begin
                n_tests++;
                if ((bus_rdata & it.mask) !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag,
                             bus_rdata & it.mask, it.exp);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp,
                      input logic [31:0] mask, input string tag);
        exp_t it;
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        it.exp = exp; it.mask = mask; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq_rise();
        @(negedge clk);
        while (irq) @(negedge clk);
        while (!irq) @(negedge clk);
    endtask

    localparam logic [31:0] TALLY_M = 32'hFFF0_0000;
    localparam logic [31:0] CNT_M   = 32'h000F_FFFF;
    localparam logic [31:0] ALL     = 32'hFFFF_FFFF;

    initial begin
        int t0, t1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state and idle bus
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq after reset", {31'b0, irq}, 0);
        chk(bus_rdata == 0, "R10 rdata with rd low", bus_rdata, 0);
        rd(4'h0, 0, ALL, "R10 ctrl after reset");
        rd(4'h4, 0, ALL, "R10 flag after reset");
        rd(4'hC, 0, ALL, "R10 view after reset");
        rd(4'h2, 0, ALL, "R10 undefined offset");

        // R2 undefined control bits are dropped
        wr(4'h0, 32'hFCF0_0005);
        rd(4'h0, 32'h0000_0005, ALL, "R2 ctrl readback masked");

        // R1/R3/R4/R8 running with interrupts unmasked, limit 2
        wr(4'h0, 32'h0300_0002);
        rd(4'h0, 32'h0300_0002, ALL, "R2 ctrl readback");
        wait_irq_rise();
        t0 = cyc;
        rd(4'h4, 32'h1, ALL, "R3 flag set on wrap");
        rd(4'h8, 32'h0010_0000, TALLY_M, "R4 tally before ack");
        rd(4'h4, 32'h0, ALL, "R4 flag cleared by ack");
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq low after ack", {31'b0, irq}, 0);
        wait_irq_rise();
        t1 = cyc;
        chk((t1 - t0) == 48, "R1 wrap interval", t1 - t0, 48);

        // R8/R6/R5 interrupt masked, tally keeps counting
        rd(4'h8, 0, 0, "ack");
        wr(4'h0, 32'h0100_0002);
        repeat (236) @(posedge clk);
        @(negedge clk);
        chk(irq == 1'b0, "R8 irq masked", {31'b0, irq}, 0);
        rd(4'hC, 32'h0050_0000, TALLY_M, "R6 tally counts five wraps");
        rd(4'hC, 32'h0050_0000, TALLY_M, "R5 peek has no side effect");
        rd(4'h4, 32'h1, ALL, "R8 flag still updates when masked");
        rd(4'h8, 32'h0050_0000, TALLY_M, "R4 ack returns old tally");
        rd(4'hC, 32'h0, TALLY_M, "R4 tally cleared by ack");

        // R7 wrap coincident with acknowledging read, limit 0
        wr(4'h0, 32'h0300_0000);
        rd(4'h8, 0, 0, "ack");
        wait_irq_rise();
        repeat (14) @(posedge clk);
        rd(4'h8, 0, 0, "ack on wrap edge");
        rd(4'hC, 32'h0010_0000, TALLY_M, "R7 tally is one after coincident ack");
        rd(4'h4, 32'h1, ALL, "R7 flag kept after coincident ack");

        // R6 saturation
        wr(4'h0, 32'h0100_0000);
        repeat (4100 * 16) @(posedge clk);
        rd(4'hC, 32'hFFF0_0000, TALLY_M, "R6 tally saturates at 4095");
        rd(4'hC, 32'hFFF0_0000, TALLY_M, "R6 tally holds at 4095");

        // R9 drain after enable withdrawn, limit 2
        wr(4'h0, 32'h0300_0002);
        rd(4'h8, 0, 0, "ack");
        wait_irq_rise();
        rd(4'h8, 0, 0, "ack");
        wr(4'h0, 32'h0200_0002);
        repeat (14) @(posedge clk);
        rd(4'hC, 32'h0000_0001, CNT_M, "R9 count continues after disable");
        repeat (40) @(posedge clk);
        rd(4'hC, 32'h0010_0000, ALL, "R9 final wrap recorded, count zero");
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq from final wrap", {31'b0, irq}, 1);
        repeat (100) @(posedge clk);
        rd(4'hC, 32'h0010_0000, ALL, "R9 counter stopped");

        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule